// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the bit-level engine for one node on a two-wire serial bus with a clock line and a data line. It samples both lines, shifts received bits into a data register, and counts clock-line edges in a small counter. It recognises start and stop conditions on the bus. Whenever software must act, it holds the clock line low. Address matching, direction choice and acknowledge policy stay with the software that loads the data and counter registers and clears the flags.

Both lines pass through two-flop synchronisers. The data line then goes through a short fixed delay before condition detection, so the clock level is stable when a data transition is judged. The counter moves on every clock-line edge, so one bit is two counts. A full-width wrap marks the end of a byte. Loading the counter two short of wrapping makes the next transfer a single bit, which is how the acknowledge slot is produced. All line outputs are pull-low enables for open-drain pads.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset the data register and counter read zero, the start, overflow and stop flags are clear, and neither line is pulled low.
- R2: In two-wire mode, a falling data line while the clock line stays high sets the start flag. The start interrupt output is high while the start flag and the start interrupt enable are both high.
- R3: Once a start has been seen, the next falling clock edge makes the unit hold the clock line low until software pulses the start-clear strobe. Before that falling edge, the clock line is not held.
- R4: On each rising clock-line edge the data register shifts one place toward its most significant bit and takes the synchronised data-line level into bit 0, so a byte sent most significant bit first ends up unchanged in the register.
- R5: The counter adds one on every clock-line edge, rising or falling. Going from all ones (15 for a 4-bit counter) back to zero sets the overflow flag. Eight bits, which are sixteen edges, starting from zero therefore leave the counter at zero with the flag set. The overflow interrupt output is high while the overflow flag and its enable are both high.
- R6: While an overflow is pending, the clock line is held low, so no further edges are counted, until software pulses the overflow-clear strobe.
- R7: Writing 14 into a 4-bit counter before releasing the clock line limits the next transfer to one bit: after its two edges the counter is zero, the overflow flag is set and the clock line is held again.
- R8: The data line is pulled low exactly when the data-drive enable is high and the most significant data register bit is 0.
- R9: With two-wire mode off, start and stop conditions on the lines set no flag, and no start-related clock hold occurs.
- R10: In two-wire mode, a rising data line while the clock line stays high sets the stop flag and drops any clock hold at once. The overflow flag is left as it was. The stop-clear strobe clears the stop flag.
- R11: A data or counter write loads the value written, visible the next cycle. Later clock-line edges continue counting from the loaded counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| twi_en | input | 1 | Two-wire mode; enables start/stop detection |
| scl_in | input | 1 | Clock line level from pad (asynchronous) |
| sda_in | input | 1 | Data line level from pad (asynchronous) |
| sda_oe | input | 1 | Data-drive enable for the most significant data bit |
| ie_start | input | 1 | Start interrupt enable |
| ie_ovf | input | 1 | Overflow interrupt enable |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | DATA_W | Data register write value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| clr_start | input | 1 | Clear start flag and its clock hold |
| clr_ovf | input | 1 | Clear overflow flag and its clock hold |
| clr_stop | input | 1 | Clear stop flag |
| data_q | output | DATA_W | Data register contents |
| cnt_q | output | CNT_W | Edge counter value |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter wrapped |
| stop_flag | output | 1 | Stop condition seen |
| irq_start | output | 1 | Start interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| scl_pull_low | output | 1 | Pull clock line low (open-drain enable) |
| sda_pull_low | output | 1 | Pull data line low (open-drain enable) |

## Verification
A corrupted edge counter shows up as an overflow flag and clock hold that arrive early or late. It is caught when the byte-end check finds a nonzero count or a missing hold, within one byte. A wrong shift register is visible on the data output at the same check. A stuck hold state blocks the modelled master, so the next bit sends no edges and the counter check after it fails. A missed start or stop condition appears as a flag mismatch within about ten cycles of the line change.

// File: rtl/twi_shift_pkg.sv
package twi_shift_pkg;

    // Per-cycle events decoded from the synchronised bus lines.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_bit;
        logic start;
        logic stop;
    } line_evt_t;

    // Flag clear strobes from software.
    typedef struct packed {
        logic start;
        logic ovf;
        logic stop;
    } flag_clr_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = line_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign line_o = pipe_q[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_shift_pkg::*;
#(
    parameter int SDA_DLY = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      twi_en,
    input  logic      scl_s,
    input  logic      sda_s,
    output line_evt_t evt
);
    typedef struct packed {
        logic scl_prev;
        logic sda_late_prev;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    sda_late;
    logic    both_high;

    // Data line delay ahead of condition detection.
    generate
        if (SDA_DLY == 0) begin : g_no_dly
            assign sda_late = sda_s;
        end else begin : g_dly
            logic [SDA_DLY-1:0] dly_d, dly_q;
            always_comb begin
                dly_d[0] = sda_s;
                for (int i = 1; i < SDA_DLY; i++) begin
                    dly_d[i] = dly_q[i-1];
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '1;
                else        dly_q <= dly_d;
            end
            assign sda_late = dly_q[SDA_DLY-1];
        end
    endgenerate

    always_comb begin
        st_d.scl_prev      = scl_s;
        st_d.sda_late_prev = sda_late;
        both_high          = scl_s & st_q.scl_prev;
        evt.scl_rise       = scl_s & ~st_q.scl_prev;
        evt.scl_fall       = ~scl_s & st_q.scl_prev;
        evt.sda_bit        = sda_s;
        evt.start          = twi_en & both_high & st_q.sda_late_prev & ~sda_late;
        evt.stop           = twi_en & both_high & ~st_q.sda_late_prev & sda_late;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl_prev: 1'b1, sda_late_prev: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/twi_shift_core.sv
module twi_shift_core
    import twi_shift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_evt_t         evt,
    input  flag_clr_t         clr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag,
    output logic              scl_hold
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              start_flag;
        logic              ovf_flag;
        logic              stop_flag;
        logic              armed;
        logic              start_hold;
        logic              ovf_hold;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     scl_edge;
    logic     wrap;

    always_comb begin
        st_d     = st_q;
        scl_edge = evt.scl_rise | evt.scl_fall;
        wrap     = ~cnt_wr & scl_edge & (st_q.cnt == CNT_MAX);

        if (data_wr)           st_d.data = data_wdata;
        else if (evt.scl_rise) st_d.data = {st_q.data[DATA_W-2:0], evt.sda_bit};

        if (cnt_wr)            st_d.cnt = cnt_wdata;
        else if (scl_edge)     st_d.cnt = st_q.cnt + 1'b1;

        if (evt.start)         st_d.start_flag = 1'b1;
        else if (clr.start)    st_d.start_flag = 1'b0;

        if (wrap)              st_d.ovf_flag = 1'b1;
        else if (clr.ovf)      st_d.ovf_flag = 1'b0;

        if (evt.stop)          st_d.stop_flag = 1'b1;
        else if (clr.stop)     st_d.stop_flag = 1'b0;

        st_d.armed      = evt.start |
                          (st_q.armed & ~evt.scl_fall & ~clr.start & ~evt.stop);
        st_d.start_hold = (st_q.start_hold | (st_q.armed & evt.scl_fall)) &
                          ~clr.start & ~evt.stop;
        st_d.ovf_hold   = wrap | (st_q.ovf_hold & ~clr.ovf & ~evt.stop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q     = st_q.data;
    assign cnt_q      = st_q.cnt;
    assign start_flag = st_q.start_flag;
    assign ovf_flag   = st_q.ovf_flag;
    assign stop_flag  = st_q.stop_flag;
    assign scl_hold   = st_q.start_hold | st_q.ovf_hold;
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit
    import twi_shift_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int SYNC_STG = 2,
    parameter int SDA_DLY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              twi_en,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              sda_oe,
    input  logic              ie_start,
    input  logic              ie_ovf,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              clr_start,
    input  logic              clr_ovf,
    input  logic              clr_stop,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag,
    output logic              irq_start,
    output logic              irq_ovf,
    output logic              scl_pull_low,
    output logic              sda_pull_low
);
    logic      scl_s, sda_s;
    line_evt_t evt;
    flag_clr_t clr;
    logic      scl_rise, scl_fall, start_evt, stop_evt;

    twi_line_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_in), .line_o(scl_s)
    );

    twi_line_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_in), .line_o(sda_s)
    );

    twi_cond_detect #(.SDA_DLY(SDA_DLY)) u_detect (
        .clk(clk), .rst_n(rst_n), .twi_en(twi_en),
        .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
    );

    always_comb begin
        clr.start = clr_start;
        clr.ovf   = clr_ovf;
        clr.stop  = clr_stop;
    end

    twi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .data_q(data_q), .cnt_q(cnt_q),
        .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
        .scl_hold(scl_pull_low)
    );

    assign scl_rise     = evt.scl_rise;
    assign scl_fall     = evt.scl_fall;
    assign start_evt    = evt.start;
    assign stop_evt     = evt.stop;
    assign irq_start    = start_flag & ie_start;
    assign irq_ovf      = ovf_flag & ie_ovf;
    assign sda_pull_low = sda_oe & ~data_q[DATA_W-1];
endmodule

// File: rtl/twi_shift_unit_chk.sv
module twi_shift_unit_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              twi_en,
    input logic              data_wr,
    input logic              cnt_wr,
    input logic              clr_start,
    input logic              clr_ovf,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              start_evt,
    input logic              stop_evt,
    input logic [DATA_W-1:0] data_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              start_flag,
    input logic              ovf_flag,
    input logic              stop_flag,
    input logic              scl_pull_low
);
    logic scl_edge;
    assign scl_edge = scl_rise | scl_fall;

    AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> start_flag); // R2

    AST_START_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_low && !clr_start && !clr_ovf && !stop_evt) |=> scl_pull_low); // R3

    AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && !data_wr) |=> (data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0]))); // R4

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !scl_edge) |=> $stable(cnt_q)); // R5

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_edge && !cnt_wr && (cnt_q == {CNT_W{1'b1}})) |=> (ovf_flag && (cnt_q == '0))); // R5

    AST_OVF_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> scl_pull_low); // R6

    AST_NO_START_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !twi_en |=> !$rose(start_flag)); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> !scl_pull_low); // R10
endmodule

bind twi_shift_unit twi_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .twi_en(twi_en),
    .data_wr(data_wr), .cnt_wr(cnt_wr),
    .clr_start(clr_start), .clr_ovf(clr_ovf),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .data_q(data_q), .cnt_q(cnt_q),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
    .scl_pull_low(scl_pull_low)
);

// File: tb/tb_twi_shift_unit.sv
`timescale 1ns/1ps
module tb_twi_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       twi_en = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, wired = 1'b1;
    logic       sda_oe = 1'b0, ie_start = 1'b1, ie_ovf = 1'b1;
    logic       data_wr = 1'b0, cnt_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [3:0] cnt_wdata = '0;
    logic       clr_start = 1'b0, clr_ovf = 1'b0, clr_stop = 1'b0;
    logic [7:0] data_q;
    logic [3:0] cnt_q;
    logic       start_flag, ovf_flag, stop_flag, irq_start, irq_ovf;
    logic       scl_pull_low, sda_pull_low;
    logic       scl_in, sda_in;
    int         n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    // Open-drain bus: master and unit both may only pull low.
    assign scl_in = scl_m & ~(wired & scl_pull_low);
    assign sda_in = sda_m & ~sda_pull_low;

    twi_shift_unit dut (
        .clk(clk), .rst_n(rst_n), .twi_en(twi_en),
        .scl_in(scl_in), .sda_in(sda_in), .sda_oe(sda_oe),
        .ie_start(ie_start), .ie_ovf(ie_ovf),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .clr_start(clr_start), .clr_ovf(clr_ovf), .clr_stop(clr_stop),
        .data_q(data_q), .cnt_q(cnt_q),
        .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
        .irq_start(irq_start), .irq_ovf(irq_ovf),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Software register access: one-cycle strobes.
    task automatic sw_op(input bit wd, input logic [7:0] d, input bit wc, input logic [3:0] c,
                         input bit cs, input bit co, input bit cp);
        data_wr = wd; data_wdata = d; cnt_wr = wc; cnt_wdata = c;
        clr_start = cs; clr_ovf = co; clr_stop = cp;
        tick(1);
        data_wr = 0; cnt_wr = 0; clr_start = 0; clr_ovf = 0; clr_stop = 0;
        tick(3);
    endtask

    task automatic send_bit(input bit b);
        int h;
        h = 6 + int'($urandom % 8);
        sda_m = b;  tick(h);
        scl_m = 1;  tick(h);
        scl_m = 0;  tick(h);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    function automatic logic [7:0] after_shift(input logic [7:0] d, input bit b);
        return {d[6:0], b};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check("R1 data", data_q, 8'h00);
        check("R1 cnt", cnt_q, 4'h0);
        check("R1 flags", {start_flag, ovf_flag, stop_flag}, 3'b000);
        check("R1 pulls", {scl_pull_low, sda_pull_low}, 2'b00);

        // R2 / R3 start and start hold
        twi_en = 1'b1;
        tick(4);
        sda_m = 0; tick(8);
        check("R2 start flag", start_flag, 1'b1);
        check("R2 irq_start", irq_start, 1'b1);
        check("R3 no hold before fall", scl_pull_low, 1'b0);
        scl_m = 0; tick(8);
        check("R3 hold after fall", scl_pull_low, 1'b1);
        check("R5 one edge counted", cnt_q, 4'h1);
        sw_op(0, 8'h00, 1, 4'h0, 1, 0, 0);
        check("R3 released by clear", scl_pull_low, 1'b0);
        check("R2 flag cleared", start_flag, 1'b0);

        // R4 / R5 / R6 first byte
        v = 8'($urandom);
        send_byte(v);
        check("R4 byte received", data_q, v);
        check("R5 cnt wrapped", cnt_q, 4'h0);
        check("R5 ovf flag", ovf_flag, 1'b1);
        check("R5 irq_ovf", irq_ovf, 1'b1);
        check("R6 hold on ovf", scl_pull_low, 1'b1);
        scl_m = 1; tick(10);
        check("R6 held: no edge", cnt_q, 4'h0);
        check("R6 bus low", scl_in, 1'b0);
        scl_m = 0; tick(4);

        // R7 acknowledge slot via counter preload; R8 drive low
        sda_oe = 1'b1;
        sw_op(1, 8'h00, 1, 4'd14, 0, 1, 0);
        check("R8 ack pulls sda", sda_pull_low, 1'b1);
        check("R6 released by clear", scl_pull_low, 1'b0);
        send_bit(1'b1);
        check("R7 cnt after ack", cnt_q, 4'h0);
        check("R7 ovf after ack", ovf_flag, 1'b1);
        check("R7 hold after ack", scl_pull_low, 1'b1);
        check("R7 ack bit read back", data_q, after_shift(8'h00, 1'b0));
        sda_oe = 1'b0;
        tick(2);
        check("R8 oe off", sda_pull_low, 1'b0);
        sw_op(0, 8'h00, 0, 4'h0, 0, 1, 0);

        // Random bytes
        for (int k = 0; k < 20; k++) begin
            v = 8'($urandom);
            send_byte(v);
            check("R4 random byte", data_q, v);
            check("R5 random wrap", {ovf_flag, cnt_q}, {1'b1, 4'h0});
            check("R6 random hold", scl_pull_low, 1'b1);
            if (k != 19) sw_op(0, 8'h00, 0, 4'h0, 0, 1, 0);
        end

        // R10 stop drops pending hold (bench lets clock line rise)
        sda_m = 0; tick(8);
        wired = 1'b0; tick(2);
        scl_m = 1; tick(8);
        sda_m = 1; tick(10);
        check("R10 stop flag", stop_flag, 1'b1);
        check("R10 hold dropped", scl_pull_low, 1'b0);
        check("R10 ovf kept", ovf_flag, 1'b1);
        sw_op(0, 8'h00, 0, 4'h0, 0, 1, 1);
        wired = 1'b1;
        check("R10 stop cleared", stop_flag, 1'b0);

        // R9 mode off
        twi_en = 1'b0;
        tick(4);
        sda_m = 0; tick(8);
        check("R9 no start", start_flag, 1'b0);
        scl_m = 0; tick(8);
        check("R9 no hold", scl_pull_low, 1'b0);
        scl_m = 1; tick(8);
        sda_m = 1; tick(8);
        check("R9 no stop", stop_flag, 1'b0);

        // R11 writes, R8 polarity
        sw_op(1, 8'hA5, 1, 4'd7, 0, 0, 0);
        check("R11 data write", data_q, 8'hA5);
        check("R11 cnt write", cnt_q, 4'd7);
        scl_m = 0; tick(8);
        check("R11 count from loaded", cnt_q, 4'd8);
        sda_oe = 1'b1; tick(2);
        check("R8 msb one no pull", sda_pull_low, 1'b0);
        sw_op(1, 8'h25, 0, 4'h0, 0, 0, 0);
        check("R8 msb zero pulls", sda_pull_low, 1'b1);
        sda_oe = 1'b0; tick(2);
        check("R8 oe low", sda_pull_low, 1'b0);

        finish_run();
    end
endmodule